// File: doc/BRIEF.md
# Fully Associative Address Translation Cache

This block holds a small set of cached page table entries in front of a page table walker. Each lookup presents a virtual address and an access kind. In the same cycle the block returns one of three results:

- a hit, with the physical address;
- a protection fault;
- a request for a table walk.

The low offset bits of the address pass through untranslated. The upper bits form the virtual page number, and every valid entry compares it against its full tag.

The walker returns refill entries on a separate write port. An entry whose page number is already cached is refreshed where it sits. A new page number takes the lowest free slot, or the slot named by a round-robin pointer when no slot is free.

A store to a writable page whose cached dirty bit is clear is reported as a miss. The resulting walk sets the dirty bit in memory, and the refreshed entry then replaces the stale one. Writing the table base register clears every entry.

Top module: `tlb_fa`

## Requirements
- R1: After reset every entry is invalid, every lookup reports a walk request, and `base_out` reads 0.
- R2: A lookup whose page number matches a valid entry that permits the access asserts `lk_hit` in the same cycle. `lk_paddr` is then the entry's physical page number joined to the 12 unchanged offset bits.
- R3: A lookup that matches no valid entry asserts `lk_walk` with `lk_hit` and `lk_fault` low.
- R4: Permission bits are bit0 read, bit1 write and bit2 execute. Access kind 0 is a load, 1 is a store, 2 is an instruction fetch, and 3 is treated as a load. A matching entry lacking the needed bit asserts `lk_fault` only.
- R5: A store that matches a writable entry with its dirty bit clear asserts `lk_walk` and not `lk_hit`. After a refill with the dirty bit set, the same store hits.
- R6: A refill whose page number is already cached overwrites that entry, so no page number is ever held twice.
- R7: A refill of a new page number fills the lowest-numbered invalid entry. When every entry is valid, it replaces the entry named by a round-robin pointer. The pointer advances only on such a replacement, and a flush does not reset it.
- R8: A pulse on `base_wr` stores `base_in` into `base_out` and invalidates all entries at that edge. A refill in the same cycle is discarded.
- R9: A lookup and a refill in the same cycle: the lookup sees the contents before the refill, and the new entry is visible from the next cycle.
- R10: With `lk_valid` low, `lk_hit`, `lk_fault`, `lk_walk` and `lk_paddr` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup present |
| lk_kind | input | 2 | Access kind (0 load, 1 store, 2 fetch, 3 load) |
| lk_vaddr | input | 32 | Virtual address |
| lk_hit | output | 1 | Translation valid |
| lk_fault | output | 1 | Protection fault |
| lk_walk | output | 1 | Table walk requested |
| lk_paddr | output | 32 | Physical address, zero unless hit |
| fill_valid | input | 1 | Refill entry present |
| fill_vpn | input | 20 | Refill virtual page number |
| fill_ppn | input | 20 | Refill physical page number |
| fill_perm | input | 3 | Refill permissions {exec, write, read} |
| fill_dirty | input | 1 | Refill dirty bit |
| base_wr | input | 1 | Write table base register |
| base_in | input | 32 | New table base value |
| base_out | output | 32 | Current table base value |

## Verification
Two pairs of functions can land in the same cycle.

The first pair is a lookup and a refill of the same page number. The bench drives both on one falling edge. It expects a walk request before the rising edge and a hit with the new frame after it.

The second pair is a refill and a base register write. The bench drives both together. It then checks that neither the refilled page nor an earlier page hits, and that the base value was taken.

// File: rtl/tlb_fa.sv
module tlb_fa #(
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20,
  parameter int OFF_W   = 12,
  parameter int ENTRIES = 8,
  parameter int BASE_W  = 32,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int VA_W   = VPN_W + OFF_W,
  localparam int PA_W   = PPN_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [1:0]        lk_kind,
  input  logic [VA_W-1:0]   lk_vaddr,
  output logic              lk_hit,
  output logic              lk_fault,
  output logic              lk_walk,
  output logic [PA_W-1:0]   lk_paddr,
  input  logic              fill_valid,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [PPN_W-1:0]  fill_ppn,
  input  logic [2:0]        fill_perm,
  input  logic              fill_dirty,
  input  logic              base_wr,
  input  logic [BASE_W-1:0] base_in,
  output logic [BASE_W-1:0] base_out
);

  logic [ENTRIES-1:0] vld, drt, match, fmatch;
  logic [VPN_W-1:0]   tag  [ENTRIES];
  logic [PPN_W-1:0]   ppn  [ENTRIES];
  logic [2:0]         perm [ENTRIES];
  logic [IDX_W-1:0]   rr, victim;
  logic               use_rr;
  logic [BASE_W-1:0]  base_q;

  wire [VPN_W-1:0] lk_vpn = lk_vaddr[VA_W-1:OFF_W];
  wire             is_store = (lk_kind == 2'd1);

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign match[i]  = vld[i] && (tag[i] == lk_vpn);
    assign fmatch[i] = vld[i] && (tag[i] == fill_vpn);
  end

  logic [PPN_W-1:0] sel_ppn;
  logic [2:0]       sel_perm;
  logic             sel_dirty;
  always_comb begin
    sel_ppn = '0; sel_perm = '0; sel_dirty = 1'b0;
    for (int i = 0; i < ENTRIES; i++)
      if (match[i]) begin
        sel_ppn   = sel_ppn | ppn[i];
        sel_perm  = sel_perm | perm[i];
        sel_dirty = sel_dirty | drt[i];
      end
  end

  logic [2:0] need;
  always_comb
    case (lk_kind)
      2'd1:    need = 3'b010;
      2'd2:    need = 3'b100;
      default: need = 3'b001;
    endcase

  wire found      = lk_valid && (|match);
  wire allowed    = |(sel_perm & need);
  wire dirty_miss = found && allowed && is_store && !sel_dirty;

  assign lk_fault = found && !allowed;
  assign lk_hit   = found && allowed && !dirty_miss;
  assign lk_walk  = lk_valid && (!(|match) || dirty_miss);
  assign lk_paddr = lk_hit ? {sel_ppn, lk_vaddr[OFF_W-1:0]} : '0;
  assign base_out = base_q;

  always_comb begin
    victim = rr;
    use_rr = 1'b1;
    if (|fmatch) begin
      use_rr = 1'b0;
      for (int i = ENTRIES-1; i >= 0; i--)
        if (fmatch[i]) victim = IDX_W'(i);
    end else if (!(&vld)) begin
      use_rr = 1'b0;
      for (int i = ENTRIES-1; i >= 0; i--)
        if (!vld[i]) victim = IDX_W'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld    <= '0;
      rr     <= '0;
      base_q <= '0;
    end else if (base_wr) begin
      vld    <= '0;
      base_q <= base_in;
    end else if (fill_valid) begin
      vld[victim] <= 1'b1;
      if (use_rr) rr <= (rr == IDX_W'(ENTRIES-1)) ? '0 : rr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      drt <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        tag[i] <= '0; ppn[i] <= '0; perm[i] <= '0;
      end
    end else if (fill_valid && !base_wr) begin
      tag[victim]  <= fill_vpn;
      ppn[victim]  <= fill_ppn;
      perm[victim] <= fill_perm;
      drt[victim]  <= fill_dirty;
    end
  end

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({lk_hit, lk_fault, lk_walk})); // R4
  AST_UNIQUE_TAG: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match)); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |-> !(lk_hit || lk_fault || lk_walk)); // R10
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    base_wr |=> !(lk_hit || lk_fault)); // R8
  AST_STORE_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_hit && is_store) |-> sel_dirty); // R5
  AST_NO_MATCH_WALKS: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && !(|match)) |-> lk_walk); // R3

endmodule

// File: tb/tb_tlb_fa.sv
module tb_tlb_fa;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0;
  logic        lk_valid = 0;
  logic [1:0]  lk_kind = 0;
  logic [31:0] lk_vaddr = 0;
  logic        lk_hit, lk_fault, lk_walk;
  logic [31:0] lk_paddr;
  logic        fill_valid = 0;
  logic [19:0] fill_vpn = 0, fill_ppn = 0;
  logic [2:0]  fill_perm = 0;
  logic        fill_dirty = 0;
  logic        base_wr = 0;
  logic [31:0] base_in = 0, base_out;

  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tlb_fa dut (.clk, .rst_n, .lk_valid, .lk_kind, .lk_vaddr, .lk_hit, .lk_fault,
              .lk_walk, .lk_paddr, .fill_valid, .fill_vpn, .fill_ppn, .fill_perm,
              .fill_dirty, .base_wr, .base_in, .base_out);

  // {valid, kind, vaddr, exp_hit, exp_fault, exp_walk, exp_paddr}
  localparam logic [69:0] VEC [13] = '{
    {1'b1, 2'd0, 32'h00010123, 3'b100, 32'h0A010123},  // R2 load on read page
    {1'b1, 2'd1, 32'h00010123, 3'b010, 32'h00000000},  // R4 store, no write bit
    {1'b1, 2'd2, 32'h00010000, 3'b010, 32'h00000000},  // R4 fetch, no exec bit
    {1'b1, 2'd1, 32'h00020FFF, 3'b100, 32'h0A020FFF},  // R2 store on dirty page
    {1'b1, 2'd0, 32'h00020004, 3'b100, 32'h0A020004},
    {1'b1, 2'd1, 32'h00030010, 3'b001, 32'h00000000},  // R5 store on clean page
    {1'b1, 2'd0, 32'h00030000, 3'b100, 32'h0A030000},
    {1'b1, 2'd2, 32'h00040800, 3'b100, 32'h0A040800},
    {1'b1, 2'd0, 32'h00040800, 3'b010, 32'h00000000},  // R4 load on exec page
    {1'b1, 2'd0, 32'h00050000, 3'b001, 32'h00000000},  // R3 absent page
    {1'b1, 2'd1, 32'h00050000, 3'b001, 32'h00000000},  // R3
    {1'b0, 2'd0, 32'h00010123, 3'b000, 32'h00000000},  // R10 idle
    {1'b1, 2'd3, 32'h00010001, 3'b100, 32'h0A010001}   // R4 kind 3 as load
  };

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic fill(input logic [19:0] vpn, input logic [19:0] pp, input logic [2:0] pm, input logic d);
    @(negedge clk);
    fill_valid = 1; fill_vpn = vpn; fill_ppn = pp; fill_perm = pm; fill_dirty = d;
    @(negedge clk);
    fill_valid = 0;
  endtask

  task automatic look(input logic [31:0] va, input logic [1:0] k, input logic [34:0] exp, input string req);
    @(negedge clk);
    lk_valid = 1; lk_kind = k; lk_vaddr = va;
    #1;
    chk({lk_hit, lk_fault, lk_walk, lk_paddr} === exp, req,
        64'({lk_hit, lk_fault, lk_walk, lk_paddr}), 64'(exp));
    lk_valid = 0;
  endtask

  task automatic flush(input logic [31:0] v);
    @(negedge clk);
    base_wr = 1; base_in = v;
    @(negedge clk);
    base_wr = 0;
  endtask

  localparam logic [2:0] WALK = 3'b001;

  initial begin
    #(CLK_PERIOD*100000);
    chk(0, "watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    look(32'h00010000, 2'd0, {WALK, 32'h0}, "R1 empty after reset");
    chk(base_out === 32'h0, "R1 base reset", 64'(base_out), 0);

    fill(20'h00010, 20'h0A010, 3'b001, 0);
    fill(20'h00020, 20'h0A020, 3'b011, 1);
    fill(20'h00030, 20'h0A030, 3'b011, 0);
    fill(20'h00040, 20'h0A040, 3'b100, 0);

    for (int i = 0; i < 13; i++) begin
      @(negedge clk);
      lk_valid = VEC[i][69]; lk_kind = VEC[i][68:67]; lk_vaddr = VEC[i][66:35];
      #1;
      chk({lk_hit, lk_fault, lk_walk, lk_paddr} === VEC[i][34:0], "R2/R3/R4/R5/R10 vector",
          64'({lk_hit, lk_fault, lk_walk, lk_paddr}), 64'(VEC[i][34:0]));
    end
    lk_valid = 0;

    // R5: refill with the dirty bit set, then the store hits
    fill(20'h00030, 20'h0B030, 3'b011, 1);
    look(32'h00030ABC, 2'd1, {3'b100, 32'h0B030ABC}, "R5 store after dirty refill");

    // R6: a second refill of the same page replaces the first copy
    fill(20'h00060, 20'h00001, 3'b001, 0);
    fill(20'h00060, 20'h00002, 3'b001, 0);
    look(32'h00060010, 2'd0, {3'b100, 32'h00002010}, "R6 duplicate overwrites");

    // R9: lookup and refill of the same page in the same cycle
    @(negedge clk);
    lk_valid = 1; lk_kind = 0; lk_vaddr = 32'h00070040;
    fill_valid = 1; fill_vpn = 20'h00070; fill_ppn = 20'h0C070; fill_perm = 3'b001; fill_dirty = 0;
    #1;
    chk({lk_hit, lk_walk} === 2'b01, "R9 old contents seen", 64'({lk_hit, lk_walk}), 1);
    @(negedge clk);
    fill_valid = 0;
    #1;
    chk({lk_hit, lk_paddr} === {1'b1, 32'h0C070040}, "R9 visible next cycle",
        64'({lk_hit, lk_paddr}), 64'({1'b1, 32'h0C070040}));
    lk_valid = 0;

    // R8: base write together with a refill
    @(negedge clk);
    base_wr = 1; base_in = 32'h12345000;
    fill_valid = 1; fill_vpn = 20'h00080; fill_ppn = 20'h0D080; fill_perm = 3'b001; fill_dirty = 0;
    @(negedge clk);
    base_wr = 0; fill_valid = 0;
    chk(base_out === 32'h12345000, "R8 base stored", 64'(base_out), 64'h12345000);
    look(32'h00010000, 2'd0, {WALK, 32'h0}, "R8 old entry flushed");
    look(32'h00080000, 2'd0, {WALK, 32'h0}, "R8 same-cycle refill discarded");

    // R7: round-robin replacement once the array is full
    for (int i = 0; i < 8; i++) fill(20'h00100 + 20'(i), 20'h01100 + 20'(i), 3'b001, 0);
    fill(20'h00108, 20'h01108, 3'b001, 0);
    fill(20'h00109, 20'h01109, 3'b001, 0);
    look(32'h00100000, 2'd0, {WALK, 32'h0}, "R7 first victim");
    look(32'h00101000, 2'd0, {WALK, 32'h0}, "R7 second victim");
    look(32'h00102000, 2'd0, {3'b100, 32'h01102000}, "R7 survivor");
    look(32'h00108000, 2'd0, {3'b100, 32'h01108000}, "R7 new entry");
    fill(20'h00103, 20'h02103, 3'b001, 0);
    fill(20'h0010A, 20'h0110A, 3'b001, 0);
    look(32'h00102000, 2'd0, {WALK, 32'h0}, "R7 pointer held over refresh");
    look(32'h00103000, 2'd0, {3'b100, 32'h02103000}, "R7 refreshed kept");

    flush(32'h00ABC000);
    for (int i = 0; i < 8; i++) fill(20'h00200 + 20'(i), 20'h01200 + 20'(i), 3'b001, 0);
    look(32'h00207000, 2'd0, {3'b100, 32'h01207000}, "R7 free slots used first");
    fill(20'h00208, 20'h01208, 3'b001, 0);
    look(32'h00203000, 2'd0, {WALK, 32'h0}, "R7 pointer survives flush");
    look(32'h00200000, 2'd0, {3'b100, 32'h01200000}, "R7 slot 0 kept");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule